// File: doc/BRIEF.md
# Register File with Load-Aware Operand Forwarding

This block holds the 32 general registers of a short in-order integer pipeline. It has two read ports and one write port. It also owns the logic around the write port: the choice between an ALU result and returning memory data, the qualification of the write strobe, and a forwarding multiplexer on each read port. An instruction presents its source indices one cycle before its operands are needed, and its own write-back lands later in the pipeline. Without forwarding, a dependent instruction that follows directly would read a stale value.

A small three-state controller tracks an outstanding load. In `LS_IDLE`, a valid instruction is accepted. A valid load moves the controller to `LS_SHADOW` (transition *load accepted*). The next edge moves it to `LS_RETURN` (transition *shadow elapsed*). The edge after that returns it to `LS_IDLE` (transition *data committed*). During the load cycle, the address result is kept out of the destination register. During the two following cycles, the instruction inputs are ignored. In `LS_RETURN`, the returning memory word is written to the load's destination register. The forwarding path taps this selected write data, so a read issued in the return cycle receives the loaded word rather than the address.

Top module: `regfile_ldbyp`

## Requirements
- R1: After reset, every register holds zero, the controller is in `LS_IDLE`, and both operands read zero.
- R2: Read indices presented in cycle n produce operands in cycle n+1. The operands include every write committed in cycle n-1 or earlier.
- R3: In `LS_IDLE`, a non-load write takes place when `instr_vld`, `has_dst` and a non-zero `dst_idx` are all present; it stores `alu_res` at `dst_idx`. Without any one of these, no register changes.
- R4: Register 0 always reads zero, is never written, and is never forwarded, including when a load targets it.
- R5: When a read index presented in cycle n equals the index written in cycle n, the operand in cycle n+1 is the data written in cycle n, not the older array contents.
- R6: A valid instruction with `is_load` set, accepted in `LS_IDLE`, writes nothing. Its `alu_res` (the address) never reaches any register or operand.
- R7: In the two cycles after an accepted load (`LS_SHADOW`, then `LS_RETURN`), the instruction inputs are ignored: no normal write and no new load. The controller is back in `LS_IDLE` on the third cycle.
- R8: In `LS_RETURN`, `ld_data` is written to the destination index captured with the load. `ld_data` is sampled in no other cycle.
- R9: A read issued in the `LS_RETURN` cycle for the load's destination gets `ld_data` as its operand in the next cycle, on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_idx_a | input | 5 | First source register index |
| rd_idx_b | input | 5 | Second source register index |
| instr_vld | input | 1 | The write-back instruction is valid |
| has_dst | input | 1 | The write-back instruction's format carries a destination (R, I, U, J) |
| is_load | input | 1 | The write-back instruction is a load |
| dst_idx | input | 5 | Destination register index of the write-back instruction |
| alu_res | input | 32 | ALU result (the address for a load) |
| ld_data | input | 32 | Memory data, valid in the second cycle after a load |
| opnd_a | output | 32 | First source operand |
| opnd_b | output | 32 | Second source operand |

## Verification
The hardest case to reach is a read that coincides with the load-return cycle and names the load's destination. Only the forwarding register can then supply the loaded word, and the address computed two cycles earlier must have left no trace. The bench drives a load whose address differs from its data. It fills both shadow cycles with valid-looking writes and loads that must be discarded, and holds `ld_data` at a decoy value outside the return cycle. In the return cycle it issues the dependent read, first on one port and then on the other. It also places a second load directly after a return and one inside a shadow, to show that only loads accepted in `LS_IDLE` start a sequence.

// File: rtl/rfb_pkg.sv
`timescale 1ns/1ps
package rfb_pkg;

    // Load sequencing state of the write-back controller.
    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_SHADOW = 2'd1,
        LS_RETURN = 2'd2
    } ld_state_e;

endpackage

// File: rtl/rfb_wb_ctrl.sv
`timescale 1ns/1ps
// Write-back controller: picks write data and index, qualifies the strobe,
// and sequences the two-cycle load shadow.
module rfb_wb_ctrl
    import rfb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_vld,
    input  logic            has_dst,
    input  logic            is_load,
    input  logic [IDXW-1:0] dst_idx,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] ld_data,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [XLEN-1:0] wr_data,
    output ld_state_e       state
);

    ld_state_e       state_nx;
    logic [IDXW-1:0] ld_dst_q;
    logic            accept;
    logic            ld_go;

    // Instructions are only taken while no load is in flight.
    assign accept = (state == LS_IDLE) && instr_vld;
    assign ld_go  = accept && is_load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            ld_dst_q <= '0;
        end else begin
            state <= state_nx;
            if (ld_go) begin
                ld_dst_q <= dst_idx;
            end
        end
    end

    // Transitions: load accepted, shadow elapsed, data committed
    always_comb begin
        state_nx = state;
        unique case (state)
            LS_IDLE:   state_nx = ld_go ? LS_SHADOW : LS_IDLE;
            LS_SHADOW: state_nx = LS_RETURN;
            LS_RETURN: state_nx = LS_IDLE;
            default:   state_nx = LS_IDLE;
        endcase
    end

    // Outputs: write strobe, index and data per state
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = dst_idx;
        wr_data = alu_res;
        unique case (state)
            LS_IDLE: begin
                // a load's address result is withheld from the register
                wr_en = accept && !is_load && has_dst && (dst_idx != '0);
            end
            LS_SHADOW: begin
                wr_en = 1'b0;
            end
            LS_RETURN: begin
                wr_en   = (ld_dst_q != '0);
                wr_idx  = ld_dst_q;
                wr_data = ld_data;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rfb_array.sv
`timescale 1ns/1ps
// Register storage: one write port, NRD registered read ports.
// A read that meets a write at the same edge returns the old contents.
module rfb_array #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    parameter int IDXW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0][IDXW-1:0]  rd_idx_q,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
            rd_idx_q <= '0;
            rd_data  <= '0;
        end else begin
            if (wr_en && (wr_idx != '0)) begin
                regs[wr_idx] <= wr_data;
            end
            for (int p = 0; p < NRD; p++) begin
                rd_idx_q[p] <= rd_idx[p];
                rd_data[p]  <= regs[rd_idx[p]];
            end
        end
    end

endmodule

// File: rtl/rfb_bypass.sv
`timescale 1ns/1ps
// Operand select for one read port: zero register, forwarded write, or array.
module rfb_bypass #(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input  logic            fwd_en,
    input  logic [IDXW-1:0] fwd_idx,
    input  logic [XLEN-1:0] fwd_data,
    input  logic [IDXW-1:0] rd_idx_q,
    input  logic [XLEN-1:0] arr_data,
    output logic [XLEN-1:0] opnd
);

    always_comb begin
        if (rd_idx_q == '0) begin
            opnd = '0;
        end else if (fwd_en && (fwd_idx == rd_idx_q)) begin
            opnd = fwd_data;
        end else begin
            opnd = arr_data;
        end
    end

endmodule

// File: rtl/regfile_ldbyp.sv
`timescale 1ns/1ps
module regfile_ldbyp
    import rfb_pkg::*;
#(
    parameter  int XLEN = 32,
    parameter  int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_idx_a,
    input  logic [IDXW-1:0] rd_idx_b,
    input  logic            instr_vld,
    input  logic            has_dst,
    input  logic            is_load,
    input  logic [IDXW-1:0] dst_idx,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);

    localparam int NRD = 2;

    logic                      wr_en;
    logic [IDXW-1:0]           wr_idx;
    logic [XLEN-1:0]           wr_data;
    ld_state_e                 ld_state;
    logic                      prev_en;
    logic [IDXW-1:0]           prev_idx;
    logic [XLEN-1:0]           prev_data;
    logic [NRD-1:0][IDXW-1:0]  rd_idx_pk;
    logic [NRD-1:0][IDXW-1:0]  rd_idx_q;
    logic [NRD-1:0][XLEN-1:0]  arr_data;
    logic [NRD-1:0][XLEN-1:0]  opnd_pk;

    assign rd_idx_pk[0] = rd_idx_a;
    assign rd_idx_pk[1] = rd_idx_b;

    rfb_wb_ctrl #(
        .XLEN (XLEN),
        .IDXW (IDXW)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_vld (instr_vld),
        .has_dst   (has_dst),
        .is_load   (is_load),
        .dst_idx   (dst_idx),
        .alu_res   (alu_res),
        .ld_data   (ld_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .state     (ld_state)
    );

    rfb_array #(
        .XLEN (XLEN),
        .NREG (NREG),
        .NRD  (NRD),
        .IDXW (IDXW)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx_pk),
        .rd_idx_q (rd_idx_q),
        .rd_data  (arr_data)
    );

    // Forwarding register: holds the final selected write of the last cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_idx  <= '0;
            prev_data <= '0;
        end else begin
            prev_en   <= wr_en && (wr_idx != '0);
            prev_idx  <= wr_idx;
            prev_data <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        rfb_bypass #(
            .XLEN (XLEN),
            .IDXW (IDXW)
        ) u_byp (
            .fwd_en   (prev_en),
            .fwd_idx  (prev_idx),
            .fwd_data (prev_data),
            .rd_idx_q (rd_idx_q[p]),
            .arr_data (arr_data[p]),
            .opnd     (opnd_pk[p])
        );
    end

    assign opnd_a = opnd_pk[0];
    assign opnd_b = opnd_pk[1];

endmodule

// File: rtl/rfb_chk.sv
`timescale 1ns/1ps
module rfb_chk
    import rfb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_vld,
    input logic            is_load,
    input logic [IDXW-1:0] dst_idx,
    input logic [IDXW-1:0] rd_idx_a,
    input logic [IDXW-1:0] rd_idx_b,
    input logic [XLEN-1:0] ld_data,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic [1:0]      state
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_r0_port_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(rd_idx_a) == '0) |-> (opnd_a == '0));

    assert_r0_port_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && ($past(rd_idx_b) == '0) |-> (opnd_b == '0));

    assert_no_write_r0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));

    assert_fwd_port_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && $past(wr_en) && ($past(rd_idx_a) == $past(wr_idx))
        |-> (opnd_a == $past(wr_data)));

    assert_fwd_port_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) && $past(wr_en) && ($past(rd_idx_b) == $past(wr_idx))
        |-> (opnd_b == $past(wr_data)));

    assert_load_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld && is_load && (state == LS_IDLE) |-> !wr_en);

    assert_shadow_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_SHADOW) |-> !wr_en);

    assert_shadow_to_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_SHADOW) |=> (state == LS_RETURN));

    assert_return_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_RETURN) |=> (state == LS_IDLE));

    assert_load_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) && ($past(state, 2) == LS_IDLE) && $past(instr_vld && is_load, 2)
        && ($past(dst_idx, 2) != '0)
        |-> wr_en && (wr_idx == $past(dst_idx, 2)) && (wr_data == ld_data));

endmodule

bind regfile_ldbyp rfb_chk #(
    .XLEN (XLEN),
    .IDXW (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_vld (instr_vld),
    .is_load   (is_load),
    .dst_idx   (dst_idx),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .ld_data   (ld_data),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .state     (ld_state)
);

// File: tb/tb_regfile_ldbyp.sv
`timescale 1ns/1ps
module tb_regfile_ldbyp;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_idx_a, rd_idx_b, dst_idx;
    logic        instr_vld, has_dst, is_load;
    logic [31:0] alu_res, ld_data;
    logic [31:0] opnd_a, opnd_b;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] DECOY = 32'hBAD0_BAD0;

    always #2.5 clk = ~clk;

    regfile_ldbyp dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .instr_vld (instr_vld),
        .has_dst   (has_dst),
        .is_load   (is_load),
        .dst_idx   (dst_idx),
        .alu_res   (alu_res),
        .ld_data   (ld_data),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return at the next falling edge,
    // where the operands for the reads given here are visible.
    task automatic issue(input logic v, input logic hd, input logic ld,
                         input logic [4:0] dst, input logic [31:0] alu,
                         input logic [31:0] ldd, input logic [4:0] ra,
                         input logic [4:0] rb);
        instr_vld = v;
        has_dst   = hd;
        is_load   = ld;
        dst_idx   = dst;
        alu_res   = alu;
        ld_data   = ldd;
        rd_idx_a  = ra;
        rd_idx_b  = rb;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 opnd_a right after reset", opnd_a, 32'h0);
        chk("R1 opnd_b right after reset", opnd_b, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd5, 5'd31);
        chk("R1 r5 cleared", opnd_a, 32'h0);
        chk("R1 r31 cleared", opnd_b, 32'h0);
    endtask

    task automatic t_write_read();
        issue(1, 1, 0, 5'd3, 32'h1111_0003, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd3, 5'd0);
        chk("R3 r3 written via array", opnd_a, 32'h1111_0003);
        chk("R2 r0 port b", opnd_b, 32'h0);
    endtask

    task automatic t_bypass();
        issue(1, 1, 0, 5'd7, 32'hA5A5_0007, DECOY, 5'd7, 5'd3);
        chk("R5 same-cycle write forwarded", opnd_a, 32'hA5A5_0007);
        chk("R2 other port from array", opnd_b, 32'h1111_0003);
        issue(1, 1, 0, 5'd7, 32'h7777_7777, DECOY, 5'd7, 5'd7);
        chk("R5 newer write beats array a", opnd_a, 32'h7777_7777);
        chk("R5 newer write beats array b", opnd_b, 32'h7777_7777);
        issue(0, 0, 0, 0, 0, DECOY, 5'd7, 5'd7);
        chk("R2 forwarded value committed", opnd_a, 32'h7777_7777);
    endtask

    task automatic t_reg_zero();
        issue(1, 1, 0, 5'd0, 32'hDEAD_BEEF, DECOY, 5'd0, 5'd0);
        chk("R4 r0 not forwarded a", opnd_a, 32'h0);
        chk("R4 r0 not forwarded b", opnd_b, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd0, 5'd0);
        chk("R4 r0 not written", opnd_a, 32'h0);
    endtask

    task automatic t_no_dst();
        issue(1, 0, 0, 5'd9, 32'h0000_0099, DECOY, 5'd9, 5'd9);
        chk("R3 no destination format", opnd_a, 32'h0);
        issue(0, 1, 0, 5'd9, 32'h0000_0999, DECOY, 5'd9, 5'd9);
        chk("R3 invalid instruction", opnd_b, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd9, 5'd0);
        chk("R3 r9 untouched", opnd_a, 32'h0);
    endtask

    task automatic t_load_port_a();
        issue(1, 1, 1, 5'd12, 32'h0000_0040, DECOY, 5'd12, 5'd0);
        chk("R6 load address not written", opnd_a, 32'h0);
        issue(1, 1, 0, 5'd13, 32'h1313_1313, DECOY, 5'd12, 5'd13);
        chk("R6 address absent in shadow", opnd_a, 32'h0);
        chk("R7 first shadow write dropped", opnd_b, 32'h0);
        issue(1, 1, 0, 5'd14, 32'h1414_1414, 32'hCAFE_F00D, 5'd12, 5'd14);
        chk("R9 load data forwarded port a", opnd_a, 32'hCAFE_F00D);
        chk("R7 return-cycle write dropped", opnd_b, 32'h0);
        issue(1, 1, 0, 5'd15, 32'h0000_0015, DECOY, 5'd12, 5'd13);
        chk("R8 load data in array", opnd_a, 32'hCAFE_F00D);
        chk("R7 r13 untouched", opnd_b, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd14, 5'd15);
        chk("R7 r14 untouched", opnd_a, 32'h0);
        chk("R3 write after load", opnd_b, 32'h0000_0015);
    endtask

    task automatic t_load_port_b();
        issue(1, 1, 1, 5'd20, 32'h0000_0080, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, 32'h2020_2020, 5'd5, 5'd20);
        chk("R9 load data forwarded port b", opnd_b, 32'h2020_2020);
        chk("R9 unrelated port a", opnd_a, 32'h0);
    endtask

    task automatic t_load_r0();
        issue(1, 1, 1, 5'd0, 32'h0000_0044, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, 32'h5555_5555, 5'd0, 5'd0);
        chk("R4 load to r0 not forwarded", opnd_a, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd0, 5'd0);
        chk("R4 load to r0 not written", opnd_b, 32'h0);
    endtask

    task automatic t_load_sequence();
        issue(1, 1, 1, 5'd21, 32'h0000_00C0, DECOY, 0, 0);
        issue(1, 1, 1, 5'd22, 32'h0000_00C4, DECOY, 0, 0);
        issue(1, 1, 1, 5'd23, 32'h0000_00C8, 32'h2121_2121, 0, 0);
        issue(1, 1, 1, 5'd25, 32'h0000_00CC, DECOY, 5'd21, 5'd22);
        chk("R8 first load committed", opnd_a, 32'h2121_2121);
        chk("R7 load in shadow ignored", opnd_b, 32'h0);
        issue(1, 1, 0, 5'd26, 32'h2626_2626, DECOY, 0, 0);
        issue(0, 0, 0, 0, 0, 32'h2525_2525, 5'd25, 5'd26);
        chk("R7 load right after return accepted", opnd_a, 32'h2525_2525);
        chk("R7 shadow write of second load dropped", opnd_b, 32'h0);
        issue(1, 1, 0, 5'd24, 32'h2424_2424, DECOY, 5'd23, 5'd0);
        chk("R7 load in return cycle ignored", opnd_a, 32'h0);
        issue(0, 0, 0, 0, 0, DECOY, 5'd24, 5'd23);
        chk("R7 idle after sequence", opnd_a, 32'h2424_2424);
        chk("R7 r23 untouched", opnd_b, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        instr_vld = 0; has_dst = 0; is_load = 0; dst_idx = 0;
        alu_res = 0; ld_data = 0; rd_idx_a = 0; rd_idx_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_bypass();
        t_reg_zero();
        t_no_dst();
        t_load_port_a();
        t_load_port_b();
        t_load_r0();
        t_load_sequence();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired before all R checks finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule